// File: doc/BRIEF.md
# Hex Command Bus Master

This block sits behind a UART receiver and transmitter and turns short typed text lines into accesses on a simple internal bus. Received characters arrive one at a time on a valid/ready stream. A state machine classifies each character and builds up a 16-bit address and, for writes, an 8-bit data value from hexadecimal digits. When a line ends correctly, the block makes exactly one read or write on the bus.

A read line looks like `R 1A2B` followed by a carriage return or line feed. A write line looks like `W 1A2B 7F` followed by an end of line. Any character that does not fit the expected sequence cancels the line, and no access is made. After a read, the returned byte is sent back as two uppercase hex characters followed by CR and LF on a valid/ready transmit stream. The receive side stays closed until that reply has been fully taken.

Top module: `hexcmd_bus_master`

## Requirements
- R1: After reset the block is idle: `bus_req` and `tx_valid` are 0 and `rx_ready` is 1.
- R2: A read line is 'R' (0x52) or 'r' (0x72), one or more whitespace characters, exactly four hex digits, optional whitespace, then an end of line. It produces one bus access with `bus_we`=0 and `bus_addr` equal to the digits.
- R3: A write line is 'W' (0x57) or 'w' (0x77), whitespace, four hex address digits, whitespace, exactly two hex data digits, optional whitespace, then an end of line. It produces one bus access with `bus_we`=1, the address, and `bus_wdata` equal to the data digits.
- R4: The characters 0-9, A-F and a-f are hex digits. The first digit typed is the most significant nibble.
- R5: Space (0x20) and horizontal tab (0x09) are both whitespace. Any run of one or more of them is accepted wherever whitespace is allowed.
- R6: A line is complete only when CR (0x0D) or LF (0x0A) arrives after its last field. Until then no access starts.
- R7: Any character that breaks the sequence cancels the line with no bus access. This covers a missing separator, a non-hex character inside a field, too few or too many digits, or a foreign character. The next well-formed line is then handled normally.
- R8: `bus_req` stays high, with address, data and direction unchanged, until a single-cycle `bus_gnt`. It drops in the cycle after the grant, so each line makes one access.
- R9: For a read, `bus_rdata` is taken in the grant cycle. The reply is the high nibble and then the low nibble as uppercase ASCII hex, then 0x0D, then 0x0A. Each byte is held on `tx_byte` with `tx_valid` until `tx_ready` takes it.
- R10: `rx_ready` is low while a bus access is pending and while reply bytes are outstanding. A byte offered during that time is not consumed.
- R11: A CR or LF arriving while idle, for example the second half of a CR LF pair, is ignored: no access and no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received character valid |
| rx_byte | input | 8 | Received character |
| rx_ready | output | 1 | Block accepts a character this cycle |
| tx_valid | output | 1 | Reply byte valid |
| tx_byte | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter takes the reply byte |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Access address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with grant |
| bus_gnt | input | 1 | One-cycle grant that ends the access |

## Verification
The assertions assume the bus side returns `bus_gnt` only while `bus_req` is high and as a single-cycle pulse. They also assume the transmitter never pulls a byte that is not valid. The bench's bus model only grants a request it currently sees, after a random wait of zero to three cycles, and drops the grant on the next cycle. Received characters are offered only when `rx_ready` is high, except in one deliberate test of R10 where a character is held against a closed receive side.

// File: rtl/hexcmd_pkg.sv
package hexcmd_pkg;

    typedef enum logic [2:0] {
        CC_OTHER,
        CC_WS,
        CC_EOL,
        CC_HEX,
        CC_RD,
        CC_WR
    } char_cls_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_SEP_A,
        ST_ADDR,
        ST_SEP_D,
        ST_DATA,
        ST_TAIL,
        ST_BUS,
        ST_RESP
    } pstate_e;

    function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
        if (n < 4'd10) begin
            return 8'h30 + {4'h0, n};
        end
        return 8'h37 + {4'h0, n};
    endfunction

endpackage

// File: rtl/hexcmd_charclass.sv
module hexcmd_charclass
    import hexcmd_pkg::*;
(
    input  logic [7:0] ch,
    output char_cls_e  cls,
    output logic [3:0] nib
);

    always_comb begin
        cls = CC_OTHER;
        nib = ch[3:0];
        if (ch >= 8'h30 && ch <= 8'h39) begin
            cls = CC_HEX;
        end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
            cls = CC_HEX;
            nib = ch[3:0] + 4'd9;
        end else if (ch == 8'h20 || ch == 8'h09) begin
            cls = CC_WS;
        end else if (ch == 8'h0D || ch == 8'h0A) begin
            cls = CC_EOL;
        end else if (ch == 8'h52 || ch == 8'h72) begin
            cls = CC_RD;
        end else if (ch == 8'h57 || ch == 8'h77) begin
            cls = CC_WR;
        end
    end

endmodule

// File: rtl/hexcmd_parser.sv
module hexcmd_parser
    import hexcmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  char_cls_e         cls,
    input  logic [3:0]        nib,
    output logic              rx_ready,
    input  logic              bus_gnt,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              resp_start,
    input  logic              resp_busy
);

    localparam int ADDR_DIG = ADDR_W / 4;
    localparam int DATA_DIG = DATA_W / 4;
    localparam int MAX_DIG  = (ADDR_DIG > DATA_DIG) ? ADDR_DIG : DATA_DIG;
    localparam int CNT_W    = $clog2(MAX_DIG + 1);
    localparam logic [CNT_W-1:0] ADDR_DIG_C = CNT_W'(ADDR_DIG);
    localparam logic [CNT_W-1:0] DATA_DIG_C = CNT_W'(DATA_DIG);

    typedef struct packed {
        pstate_e           st;
        logic              is_wr;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } preg_t;

    preg_t q, d;
    logic  take;

    assign rx_ready = (q.st != ST_BUS) && (q.st != ST_RESP);
    assign take     = rx_valid && rx_ready;

    always_comb begin
        d          = q;
        resp_start = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (take && (cls == CC_RD || cls == CC_WR)) begin
                    d.st    = ST_CMD;
                    d.is_wr = (cls == CC_WR);
                    d.cnt   = '0;
                    d.addr  = '0;
                    d.data  = '0;
                end
            end
            ST_CMD: begin
                if (take) begin
                    d.st = (cls == CC_WS) ? ST_SEP_A : ST_IDLE;
                end
            end
            ST_SEP_A: begin
                if (take) begin
                    if (cls == CC_HEX) begin
                        d.st   = ST_ADDR;
                        d.addr = {q.addr[ADDR_W-5:0], nib};
                        d.cnt  = CNT_W'(1);
                    end else if (cls != CC_WS) begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_ADDR: begin
                if (take) begin
                    if (cls == CC_HEX && q.cnt < ADDR_DIG_C) begin
                        d.addr = {q.addr[ADDR_W-5:0], nib};
                        d.cnt  = q.cnt + 1'b1;
                    end else if (q.cnt == ADDR_DIG_C && cls == CC_WS) begin
                        d.st  = q.is_wr ? ST_SEP_D : ST_TAIL;
                        d.cnt = '0;
                    end else if (q.cnt == ADDR_DIG_C && cls == CC_EOL && !q.is_wr) begin
                        d.st = ST_BUS;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_SEP_D: begin
                if (take) begin
                    if (cls == CC_HEX) begin
                        d.st   = ST_DATA;
                        d.data = {q.data[DATA_W-5:0], nib};
                        d.cnt  = CNT_W'(1);
                    end else if (cls != CC_WS) begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (take) begin
                    if (cls == CC_HEX && q.cnt < DATA_DIG_C) begin
                        d.data = {q.data[DATA_W-5:0], nib};
                        d.cnt  = q.cnt + 1'b1;
                    end else if (q.cnt == DATA_DIG_C && cls == CC_WS) begin
                        d.st = ST_TAIL;
                    end else if (q.cnt == DATA_DIG_C && cls == CC_EOL) begin
                        d.st = ST_BUS;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_TAIL: begin
                if (take) begin
                    if (cls == CC_EOL) begin
                        d.st = ST_BUS;
                    end else if (cls != CC_WS) begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_BUS: begin
                if (bus_gnt) begin
                    if (q.is_wr) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.st       = ST_RESP;
                        resp_start = 1'b1;
                    end
                end
            end
            ST_RESP: begin
                if (!resp_busy) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, is_wr: 1'b0, cnt: '0, addr: '0, data: '0};
        end else begin
            q <= d;
        end
    end

    assign bus_req   = (q.st == ST_BUS);
    assign bus_we    = q.is_wr;
    assign bus_addr  = q.addr;
    assign bus_wdata = q.data;

endmodule

// File: rtl/hexcmd_resp.sv
module hexcmd_resp
    import hexcmd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] value,
    output logic              busy,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_ready
);

    localparam int NDIG   = DATA_W / 4;
    localparam int NBYTES = NDIG + 2;
    localparam int IW     = $clog2(NBYTES + 1);
    localparam logic [IW-1:0] NDIG_C = IW'(NDIG);
    localparam logic [IW-1:0] LAST_C = IW'(NBYTES - 1);

    typedef struct packed {
        logic              busy;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] val;
    } rreg_t;

    rreg_t q, d;

    always_comb begin
        d = q;
        if (start && !q.busy) begin
            d.busy = 1'b1;
            d.idx  = '0;
            d.val  = value;
        end else if (q.busy && tx_ready) begin
            if (q.idx == LAST_C) begin
                d.busy = 1'b0;
            end else begin
                d.idx = q.idx + 1'b1;
            end
            if (q.idx < NDIG_C) begin
                d.val = {q.val[DATA_W-5:0], 4'h0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, idx: '0, val: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (q.idx < NDIG_C) begin
            tx_byte = nib_to_ascii(q.val[DATA_W-1 -: 4]);
        end else if (q.idx == NDIG_C) begin
            tx_byte = 8'h0D;
        end else begin
            tx_byte = 8'h0A;
        end
    end

    assign busy     = q.busy;
    assign tx_valid = q.busy;

endmodule

// File: rtl/hexcmd_bus_master.sv
module hexcmd_bus_master
    import hexcmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_gnt
);

    char_cls_e  cls;
    logic [3:0] nib;
    logic       resp_start;
    logic       resp_busy;

    hexcmd_charclass cc_i (
        .ch  (rx_byte),
        .cls (cls),
        .nib (nib)
    );

    hexcmd_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) prs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .cls        (cls),
        .nib        (nib),
        .rx_ready   (rx_ready),
        .bus_gnt    (bus_gnt),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .resp_start (resp_start),
        .resp_busy  (resp_busy)
    );

    hexcmd_resp #(.DATA_W(DATA_W)) rsp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (resp_start),
        .value    (bus_rdata),
        .busy     (resp_busy),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte),
        .tx_ready (tx_ready)
    );

endmodule

// File: rtl/hexcmd_checker.sv
module hexcmd_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_byte,
    input logic              tx_ready,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_gnt
);

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    p_req_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt) |=> !bus_req);

    p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    p_tx_not_during_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !bus_req);

    p_rx_closed_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !rx_ready);

    p_rx_closed_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);

    p_req_after_char_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(rx_valid && rx_ready));

endmodule

bind hexcmd_bus_master hexcmd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .tx_ready  (tx_ready),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_gnt   (bus_gnt)
);

// File: tb/hexcmd_bus_master_tb.sv
module hexcmd_bus_master_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_ready = 1'b0;
    logic        bus_req;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = 8'h00;
    logic        bus_gnt = 1'b0;

    always #5 clk = ~clk;

    hexcmd_bus_master dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .rx_ready  (rx_ready),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .tx_ready  (tx_ready),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_gnt   (bus_gnt)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] log_addr [0:1023];
    logic        log_we   [0:1023];
    logic [7:0]  log_wd   [0:1023];
    logic [7:0]  log_rd   [0:1023];
    int          n_acc = 0;
    logic [7:0]  tx_log [0:4095];
    int          n_tx = 0;
    bit          tx_hold_low = 1'b0;
    bit          running = 1'b0;
    int          r8_viol = 0;
    int          r9_viol = 0;
    int          r10_viol = 0;
    logic [7:0]  cbuf [0:63];
    int          clen = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] hexch(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction

    // Bus model: grants a visible request after a random wait, logs each access (R8)
    initial begin
        int wait_cnt;
        bit prev_req;
        logic [15:0] pa;
        logic        pw;
        logic [7:0]  pd;
        wait_cnt = 0;
        prev_req = 1'b0;
        forever begin
            @(negedge clk);
            if (bus_gnt) begin
                bus_gnt = 1'b0;
                if (bus_req) r8_viol++;
                prev_req = 1'b0;
            end else if (bus_req && running) begin
                if (prev_req && (bus_addr !== pa || bus_we !== pw || bus_wdata !== pd)) r8_viol++;
                pa = bus_addr; pw = bus_we; pd = bus_wdata;
                prev_req = 1'b1;
                if (wait_cnt == 0) begin
                    bus_rdata = 8'($urandom);
                    bus_gnt   = 1'b1;
                    log_addr[n_acc] = bus_addr;
                    log_we[n_acc]   = bus_we;
                    log_wd[n_acc]   = bus_wdata;
                    log_rd[n_acc]   = bus_rdata;
                    n_acc++;
                    wait_cnt = int'($urandom % 4);
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    // Transmit model and receive-side monitor (R9, R10)
    initial begin
        bit pv;
        bit pr;
        logic [7:0] pb;
        pv = 1'b0; pr = 1'b0; pb = 8'h00;
        forever begin
            @(negedge clk);
            if (running) begin
                if (pv && !pr && (!tx_valid || tx_byte !== pb)) r9_viol++;
                if ((bus_req || tx_valid) && rx_ready) r10_viol++;
                tx_ready = tx_hold_low ? 1'b0 : 1'($urandom % 2);
                if (tx_valid && tx_ready) begin
                    tx_log[n_tx] = tx_byte;
                    n_tx++;
                end
                pv = tx_valid; pr = tx_ready; pb = tx_byte;
            end
        end
    end

    task automatic push(input logic [7:0] b);
        cbuf[clen] = b;
        clen++;
    endtask

    task automatic push_str(input string s);
        for (int i = 0; i < s.len(); i++) push(s[i]);
    endtask

    task automatic push_ws();
        int k;
        k = 1 + int'($urandom % 3);
        for (int i = 0; i < k; i++) push(($urandom % 2) ? 8'h20 : 8'h09);
    endtask

    task automatic push_hex(input logic [3:0] n);
        logic [7:0] c;
        c = hexch(n);
        if (n >= 4'd10 && ($urandom % 2)) c = c + 8'h20;
        push(c);
    endtask

    task automatic put_byte(input logic [7:0] b);
        while (!rx_ready) @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic settle();
        int quiet;
        quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (rx_ready && !tx_valid && !bus_req) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic send_buf();
        for (int i = 0; i < clen; i++) put_byte(cbuf[i]);
        settle();
        clen = 0;
    endtask

    task automatic expect_none(input int a0, input int t0, input string req);
        check(n_acc == a0, req, "no access count", n_acc, a0);
        check(n_tx == t0, req, "no reply count", n_tx, t0);
    endtask

    task automatic expect_acc(input int a0, input int t0, input bit we,
                              input logic [15:0] addr, input logic [7:0] wd, input string req);
        check(n_acc == a0 + 1, req, "access count", n_acc, a0 + 1);
        if (n_acc == a0 + 1) begin
            check(log_we[a0] == we, req, "direction", log_we[a0], we);
            check(log_addr[a0] == addr, req, "address", log_addr[a0], addr);
            if (we) begin
                check(log_wd[a0] == wd, req, "write data", log_wd[a0], wd);
                check(n_tx == t0, req, "no reply after write", n_tx, t0);
            end else begin
                check(n_tx == t0 + 4, "R9", "reply length", n_tx, t0 + 4);
                if (n_tx == t0 + 4) begin
                    check(tx_log[t0] == hexch(log_rd[a0][7:4]), "R9", "reply hi", tx_log[t0], hexch(log_rd[a0][7:4]));
                    check(tx_log[t0+1] == hexch(log_rd[a0][3:0]), "R9", "reply lo", tx_log[t0+1], hexch(log_rd[a0][3:0]));
                    check(tx_log[t0+2] == 8'h0D, "R9", "reply CR", tx_log[t0+2], 8'h0D);
                    check(tx_log[t0+3] == 8'h0A, "R9", "reply LF", tx_log[t0+3], 8'h0A);
                end
            end
        end
    endtask

    // Watchdog
    initial begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int a0;
        int t0;
        bit we;
        logic [15:0] addr;
        logic [7:0] wd;
        int eol_pos;
        int bad;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);
        check(tx_valid == 1'b0, "R1", "tx_valid after reset", tx_valid, 0);
        check(rx_ready == 1'b1, "R1", "rx_ready after reset", rx_ready, 1);
        running = 1'b1;

        // R2 R4 read with mixed-case digits
        a0 = n_acc; t0 = n_tx;
        push_str("R 00Ff"); push(8'h0D); send_buf();
        expect_acc(a0, t0, 1'b0, 16'h00FF, 8'h00, "R2");

        // R3 R5 write with tabs, lowercase command, LF end
        a0 = n_acc; t0 = n_tx;
        push_str("w"); push(8'h09); push(8'h09); push_str("ABCD 5a"); push(8'h0A); send_buf();
        expect_acc(a0, t0, 1'b1, 16'hABCD, 8'h5A, "R3");

        // R5 trailing whitespace before end of line
        a0 = n_acc; t0 = n_tx;
        push_str("r 1234  "); push(8'h09); push(8'h0D); send_buf();
        expect_acc(a0, t0, 1'b0, 16'h1234, 8'h00, "R5");

        // R7 aborts
        a0 = n_acc; t0 = n_tx;
        push_str("R1234"); push(8'h0D); send_buf();
        expect_none(a0, t0, "R7");
        push_str("R 12G4"); push(8'h0D); send_buf();
        expect_none(a0, t0, "R7");
        push_str("W 1234 5"); push(8'h0D); send_buf();
        expect_none(a0, t0, "R7");
        push_str("R 12345"); push(8'h0D); send_buf();
        expect_none(a0, t0, "R7");
        push_str("W 12 34"); push(8'h0A); send_buf();
        expect_none(a0, t0, "R7");
        push_str("R 9abc"); push(8'h0D); send_buf();
        expect_acc(a0, t0, 1'b0, 16'h9ABC, 8'h00, "R7");

        // R11 stray end-of-line characters in idle
        a0 = n_acc; t0 = n_tx;
        push(8'h0D); push(8'h0A); push(8'h0A); send_buf();
        expect_none(a0, t0, "R11");

        // R6 no access before end of line
        a0 = n_acc; t0 = n_tx;
        push_str("R 0042"); send_buf();
        expect_none(a0, t0, "R6");
        push(8'h0D); send_buf();
        expect_acc(a0, t0, 1'b0, 16'h0042, 8'h00, "R6");

        // R10 byte held against a closed receive side is not consumed
        a0 = n_acc; t0 = n_tx;
        tx_hold_low = 1'b1;
        put_byte(8'h52); put_byte(8'h20); put_byte(8'h37); put_byte(8'h37);
        put_byte(8'h37); put_byte(8'h37); put_byte(8'h0D);
        repeat (12) @(negedge clk);
        check(tx_valid == 1'b1, "R10", "reply pending", tx_valid, 1);
        check(rx_ready == 1'b0, "R10", "rx closed during reply", rx_ready, 0);
        rx_byte = 8'h57; rx_valid = 1'b1;
        repeat (5) @(negedge clk);
        rx_valid = 1'b0;
        tx_hold_low = 1'b0;
        settle();
        expect_acc(a0, t0, 1'b0, 16'h7777, 8'h00, "R10");
        a0 = n_acc; t0 = n_tx;
        push_str("W 1111 22"); push(8'h0D); send_buf();
        expect_acc(a0, t0, 1'b1, 16'h1111, 8'h22, "R10");

        // Random well-formed and corrupted lines (R2 R3 R4 R5 R6 R7 R11)
        for (int n = 0; n < 150; n++) begin
            a0 = n_acc; t0 = n_tx;
            we   = 1'($urandom % 2);
            addr = 16'($urandom);
            wd   = 8'($urandom);
            clen = 0;
            if (we) push(($urandom % 2) ? 8'h57 : 8'h77);
            else    push(($urandom % 2) ? 8'h52 : 8'h72);
            push_ws();
            for (int i = 3; i >= 0; i--) push_hex(addr[i*4 +: 4]);
            if (we) begin
                push_ws();
                push_hex(wd[7:4]);
                push_hex(wd[3:0]);
            end
            if ($urandom % 3 == 0) push_ws();
            eol_pos = clen;
            push(($urandom % 2) ? 8'h0D : 8'h0A);
            if ($urandom % 4 == 0) push(($urandom % 2) ? 8'h0A : 8'h0D);
            bad = ($urandom % 5 == 0) ? 1 : 0;
            if (bad != 0) cbuf[$urandom % eol_pos] = 8'h5A;
            send_buf();
            if (bad != 0) expect_none(a0, t0, "R7");
            else          expect_acc(a0, t0, we, addr, wd, we ? "R3" : "R2");
        end

        check(r8_viol == 0, "R8", "request hold and single access violations", r8_viol, 0);
        check(r9_viol == 0, "R9", "reply byte hold violations", r9_viol, 0);
        check(r10_viol == 0, "R10", "rx_ready open during access or reply", r10_viol, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule